// File: doc/BRIEF.md
# SDRAM Bank Timing and Refresh Scheduler

This block sits between a memory controller's command selector and the SDRAM command pins. The selector presents one candidate command per cycle (row activate, column read, column write, precharge of one bank, precharge of every bank, auto refresh or mode register load) together with a 2-bit bank number. The scheduler tracks which of the four internal banks holds an open row. It keeps one down-counter for each minimum spacing that applies. In the same cycle it answers whether the candidate may go out now.

All spacings are run-time inputs given in clock cycles, so one netlist serves every speed grade. Typical sets are 3/6/9/3 cycles for row-to-column, minimum row-open, row cycle and precharge at 125 MHz, and 2/5/7/2 at 100 MHz. A separate interval counter raises a refresh request every programmed number of cycles, which is 15.625 us worth of clocks in normal use. The request stays up until an auto refresh is granted. While it is up, new row activations are held back so the banks drain. Each bank also reports when its row has been open longer than a programmed limit, which stands for the 100 us maximum row-open time.

A spacing of N cycles means the later command may be granted no earlier than N cycles after the earlier one. A value of 0 acts like 1, so back-to-back is the tightest spacing.

Top module: `sdram_bank_sched`

## Requirements
- R1: While rst_n is low at a clock edge, all banks return to closed, every spacing counter clears, the refresh request drops and the refresh interval count restarts from zero.
- R2: An activate (req_cmd 1) to bank b is granted only if bank b is closed, at least cfg_trp cycles have passed since bank b was closed, at least cfg_trc cycles have passed since bank b's last activate, at least cfg_trrd cycles have passed since any activate, and refresh_req is low. A granted activate opens bank b.
- R3: A read (req_cmd 2) or write (req_cmd 3) to bank b is granted only if bank b is open and at least cfg_trcd cycles have passed since its activate. Column commands may follow each other in consecutive cycles.
- R4: A single-bank precharge (req_cmd 4) to an open bank is granted only once cfg_tras cycles have passed since its activate. It closes the bank and starts that bank's cfg_trp window. A precharge to a closed bank is granted and changes nothing.
- R5: A precharge of all banks (req_cmd 5) is granted only when every open bank has met its cfg_tras window. It closes all open banks and starts each one's cfg_trp window.
- R6: An auto refresh (req_cmd 6) is granted only when all banks are closed and past their cfg_trp windows. It clears refresh_req and blocks every command for cfg_trc cycles.
- R7: A mode register load (req_cmd 7) is granted under the same bank conditions as R6 and blocks every command for cfg_tmrd cycles.
- R8: refresh_req rises cfg_refi cycles after reset (cfg_refi at least 1) and again every cfg_refi cycles after that. It stays high until a refresh is granted. A new interval expiry in the same cycle as a refresh grant keeps it high.
- R9: grant is high in the cycle a legal request is presented, with grant_cmd and grant_bank equal to the request, and bank_open shows the open banks from the next cycle on.
- R10: close_req[b] is high while bank b is open and at least cfg_tras_max cycles have passed since its activate.
- R11: A no-operation code (req_cmd 0), or req_valid low, is never granted, and grant_cmd reads 0 whenever grant is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Candidate command present |
| req_cmd | input | 3 | Candidate command code (0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge all, 6 refresh, 7 mode load) |
| req_bank | input | 2 | Candidate bank number |
| cfg_trcd | input | 4 | Activate to column spacing, cycles |
| cfg_tras | input | 4 | Minimum row-open time, cycles |
| cfg_trc | input | 4 | Activate to activate on one bank, and refresh busy time, cycles |
| cfg_trp | input | 4 | Precharge to activate or refresh, cycles |
| cfg_trrd | input | 4 | Activate to activate on any bank, cycles |
| cfg_tmrd | input | 4 | Mode load busy time, cycles |
| cfg_refi | input | 16 | Refresh interval, cycles |
| cfg_tras_max | input | 16 | Row-open age that raises close_req, cycles |
| grant | output | 1 | Candidate accepted this cycle |
| grant_cmd | output | 3 | Accepted command code, 0 when none |
| grant_bank | output | 2 | Accepted bank number |
| refresh_req | output | 1 | Auto refresh owed |
| bank_open | output | 4 | One bit per bank with an open row |
| close_req | output | 4 | One bit per bank open past its age limit |

## Verification
A spacing counter that is loaded one value off, or not loaded at all, shows at the ports as a grant one cycle early or late. This appears the first time the bench holds that command until it passes. That makes the held-request stimulus the main probe. A wrong open or closed flag shows within one cycle on bank_open, and later as column commands granted to a closed bank. A refresh interval count off by one shifts the rise of refresh_req. Since the interval repeats, that error appears within the first few hundred cycles of each phase. The bench compares every output on every cycle against a model built from grant times.

// File: rtl/sdram_sched_pkg.sv
// Shared command codes for the SDRAM bank scheduler.
// Assumes a 3-bit command field as seen on the request port.
package sdram_sched_pkg;
    typedef enum logic [2:0] {
        SC_NOP  = 3'd0,
        SC_ACT  = 3'd1,
        SC_RD   = 3'd2,
        SC_WR   = 3'd3,
        SC_PRE  = 3'd4,
        SC_PREA = 3'd5,
        SC_REF  = 3'd6,
        SC_MRS  = 3'd7
    } sched_cmd_e;
endpackage

// File: rtl/sdram_dn_timer.sv
// Spacing down-counter: a load of span N makes 'expired' rise N cycles later.
// Assumes a span of 0 acts as 1. The count saturates at zero.
module sdram_dn_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] span,
    output logic         expired
);
    logic [W-1:0] cnt;

    // count down towards zero, reload on a qualifying grant
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (span == '0) ? '0 : span - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_TMR_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        load && (span > 1) |=> !expired); // R2
endmodule

// File: rtl/sdram_bank_track.sv
// State of one SDRAM bank: open flag, the four per-bank spacing timers and
// the row-open age. Assumes the gate only asserts do_act on a closed bank and
// do_close on an open bank.
module sdram_bank_track #(
    parameter int TW = 4,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_act,
    input  logic          do_close,
    input  logic [TW-1:0] cfg_trcd,
    input  logic [TW-1:0] cfg_tras,
    input  logic [TW-1:0] cfg_trc,
    input  logic [TW-1:0] cfg_trp,
    input  logic [RW-1:0] cfg_tras_max,
    output logic          is_open,
    output logic          act_ok,
    output logic          col_ok,
    output logic          pre_ok,
    output logic          rest_ok,
    output logic          close_req
);
    logic          rcd_done, ras_done, rc_done, rp_done;
    logic [RW-1:0] age;

    sdram_dn_timer #(.W(TW)) u_rcd (.clk(clk), .rst_n(rst_n), .load(do_act),
        .span(cfg_trcd), .expired(rcd_done));
    sdram_dn_timer #(.W(TW)) u_ras (.clk(clk), .rst_n(rst_n), .load(do_act),
        .span(cfg_tras), .expired(ras_done));
    sdram_dn_timer #(.W(TW)) u_rc  (.clk(clk), .rst_n(rst_n), .load(do_act),
        .span(cfg_trc), .expired(rc_done));
    sdram_dn_timer #(.W(TW)) u_rp  (.clk(clk), .rst_n(rst_n), .load(do_close),
        .span(cfg_trp), .expired(rp_done));

    // open flag follows activate and close events
    always_ff @(posedge clk) begin
        if (!rst_n)
            is_open <= 1'b0;
        else if (do_act)
            is_open <= 1'b1;
        else if (do_close)
            is_open <= 1'b0;
    end

    // cycles since activate, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= '0;
        else if (do_act)
            age <= RW'(1);
        else if (is_open && (age != '1))
            age <= age + 1'b1;
    end

    // per-bank legality terms for the command gate
    always_comb begin
        act_ok    = !is_open && rp_done && rc_done;
        col_ok    = is_open && rcd_done;
        pre_ok    = !is_open || ras_done;
        rest_ok   = !is_open && rp_done;
        close_req = is_open && (age >= cfg_tras_max);
    end

    AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> !is_open); // R2
    AST_OPEN_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |=> is_open); // R9
    AST_CLOSED_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        do_close |=> !is_open); // R4
endmodule

// File: rtl/sdram_refresh_timer.sv
// Refresh interval counter and pending flag. Assumes cfg_refi stays constant
// between resets; values 0 and 1 both expire every cycle.
module sdram_refresh_timer #(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] cfg_refi,
    input  logic          ref_done,
    output logic          pend
);
    logic [RW-1:0] cnt;
    logic          tick;

    assign tick = (cfg_refi <= RW'(1)) || (cnt >= cfg_refi - 1'b1);

    // interval count, restarting on each expiry
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // pending flag: expiry sets it (and wins), a granted refresh clears it
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (tick)
            pend <= 1'b1;
        else if (ref_done)
            pend <= 1'b0;
    end

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !ref_done |=> pend); // R8
    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done && !tick |=> !pend); // R8
endmodule

// File: rtl/sdram_bank_sched.sv
// Top: grants one SDRAM command per cycle once every applicable spacing has
// elapsed. Assumes the requester holds or changes its candidate freely; the
// grant is combinational from the request and registered state.
module sdram_bank_sched
    import sdram_sched_pkg::*;
#(
    parameter int NB = 4,
    parameter int TW = 4,
    parameter int RW = 16,
    localparam int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_cmd,
    input  logic [BW-1:0] req_bank,
    input  logic [TW-1:0] cfg_trcd,
    input  logic [TW-1:0] cfg_tras,
    input  logic [TW-1:0] cfg_trc,
    input  logic [TW-1:0] cfg_trp,
    input  logic [TW-1:0] cfg_trrd,
    input  logic [TW-1:0] cfg_tmrd,
    input  logic [RW-1:0] cfg_refi,
    input  logic [RW-1:0] cfg_tras_max,
    output logic          grant,
    output logic [2:0]    grant_cmd,
    output logic [BW-1:0] grant_bank,
    output logic          refresh_req,
    output logic [NB-1:0] bank_open,
    output logic [NB-1:0] close_req
);
    sched_cmd_e    cmd;
    logic [NB-1:0] act_ok, col_ok, pre_ok, rest_ok;
    logic [NB-1:0] do_act, do_close;
    logic          rrd_done, quiet_done, legal;
    logic          g_act, g_ref, g_mrs, quiet_load;
    logic [TW-1:0] quiet_span;

    assign cmd = sched_cmd_e'(req_cmd);

    // one tracker per bank
    for (genvar b = 0; b < NB; b++) begin : g_bank
        sdram_bank_track #(.TW(TW), .RW(RW)) u_trk (
            .clk(clk), .rst_n(rst_n),
            .do_act(do_act[b]), .do_close(do_close[b]),
            .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_trc(cfg_trc),
            .cfg_trp(cfg_trp), .cfg_tras_max(cfg_tras_max),
            .is_open(bank_open[b]), .act_ok(act_ok[b]), .col_ok(col_ok[b]),
            .pre_ok(pre_ok[b]), .rest_ok(rest_ok[b]), .close_req(close_req[b])
        );
        // bank-directed events derived from the grant
        assign do_act[b]   = g_act && (req_bank == BW'(b));
        assign do_close[b] = grant && bank_open[b] &&
                             ((cmd == SC_PREA) || ((cmd == SC_PRE) && (req_bank == BW'(b))));
    end

    // cross-bank activate spacing
    sdram_dn_timer #(.W(TW)) u_rrd (.clk(clk), .rst_n(rst_n), .load(g_act),
        .span(cfg_trrd), .expired(rrd_done));

    // device-wide busy window after refresh or mode load
    sdram_dn_timer #(.W(TW)) u_quiet (.clk(clk), .rst_n(rst_n), .load(quiet_load),
        .span(quiet_span), .expired(quiet_done));

    sdram_refresh_timer #(.RW(RW)) u_refi (.clk(clk), .rst_n(rst_n),
        .cfg_refi(cfg_refi), .ref_done(g_ref), .pend(refresh_req));

    // legality of the candidate against bank and global state
    always_comb begin
        unique case (cmd)
            SC_ACT:         legal = act_ok[req_bank] && rrd_done && !refresh_req;
            SC_RD, SC_WR:   legal = col_ok[req_bank];
            SC_PRE:         legal = pre_ok[req_bank];
            SC_PREA:        legal = &pre_ok;
            SC_REF, SC_MRS: legal = &rest_ok;
            default:        legal = 1'b0;
        endcase
    end

    // grant and its decoded side effects
    always_comb begin
        grant      = req_valid && quiet_done && legal;
        grant_cmd  = grant ? req_cmd : 3'd0;
        grant_bank = req_bank;
        g_act      = grant && (cmd == SC_ACT);
        g_ref      = grant && (cmd == SC_REF);
        g_mrs      = grant && (cmd == SC_MRS);
        quiet_load = g_ref || g_mrs;
        quiet_span = g_ref ? cfg_trc : cfg_tmrd;
    end

    AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        g_ref |-> (bank_open == '0)); // R6
    AST_MRS_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        g_mrs |-> (bank_open == '0)); // R7
    AST_COL_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        grant && ((cmd == SC_RD) || (cmd == SC_WR)) |-> bank_open[req_bank]); // R3
    AST_ACT_NO_REFRESH_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        g_act |-> !refresh_req); // R2
    AST_NOP_NEVER_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (req_valid && (cmd != SC_NOP))); // R11
    AST_PREA_CLOSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        grant && (cmd == SC_PREA) |=> (bank_open == '0)); // R5
    AST_QUIET_AFTER_MRS: assert property (@(posedge clk) disable iff (!rst_n)
        g_mrs && (cfg_tmrd > 1) |=> !grant); // R7
endmodule

// File: tb/sdram_bank_sched_tb.sv
// Cycle-by-cycle reference model of the scheduler, compared on every clock.
// The model keeps, per constraint, the earliest cycle at which it is met.
module sdram_bank_sched_tb;
    localparam int NB = 4;
    localparam int MAXCYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_cmd;
    logic [1:0]  req_bank;
    logic [3:0]  cfg_trcd, cfg_tras, cfg_trc, cfg_trp, cfg_trrd, cfg_tmrd;
    logic [15:0] cfg_refi, cfg_tras_max;
    logic        grant, refresh_req;
    logic [2:0]  grant_cmd;
    logic [1:0]  grant_bank;
    logic [3:0]  bank_open, close_req;

    always #5 clk = ~clk;

    sdram_bank_sched u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras),
        .cfg_trc(cfg_trc), .cfg_trp(cfg_trp), .cfg_trrd(cfg_trrd),
        .cfg_tmrd(cfg_tmrd), .cfg_refi(cfg_refi), .cfg_tras_max(cfg_tras_max),
        .grant(grant), .grant_cmd(grant_cmd), .grant_bank(grant_bank),
        .refresh_req(refresh_req), .bank_open(bank_open), .close_req(close_req)
    );

    int vectors = 0;
    int errors  = 0;
    int cyc;
    int m_open[NB], m_act_at[NB];
    int rdy_rcd[NB], rdy_ras[NB], rdy_rc[NB], rdy_rp[NB];
    int rdy_rrd, rdy_quiet;
    bit m_pend;
    bit last_granted = 1'b1;

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd1:       return "R2";
            3'd2, 3'd3: return "R3";
            3'd4:       return "R4";
            3'd5:       return "R5";
            3'd6:       return "R6";
            3'd7:       return "R7";
            default:    return "R11";
        endcase
    endfunction

    function automatic bit ready(input int r);
        return cyc >= r;
    endfunction

    task automatic model_reset();
        cyc = 0; m_pend = 0; rdy_rrd = 0; rdy_quiet = 0;
        for (int b = 0; b < NB; b++) begin
            m_open[b] = 0; m_act_at[b] = 0;
            rdy_rcd[b] = 0; rdy_ras[b] = 0; rdy_rc[b] = 0; rdy_rp[b] = 0;
        end
    endtask

    function automatic bit model_grant();
        bit ok;
        int b;
        b = int'(req_bank);
        if (!req_valid || !ready(rdy_quiet)) return 1'b0;
        case (req_cmd)
            3'd1: ok = !m_open[b] && ready(rdy_rp[b]) && ready(rdy_rc[b]) &&
                       ready(rdy_rrd) && !m_pend;
            3'd2, 3'd3: ok = m_open[b] && ready(rdy_rcd[b]);
            3'd4: ok = !m_open[b] || ready(rdy_ras[b]);
            3'd5: begin
                ok = 1'b1;
                for (int k = 0; k < NB; k++)
                    if (m_open[k] && !ready(rdy_ras[k])) ok = 1'b0;
            end
            3'd6, 3'd7: begin
                ok = 1'b1;
                for (int k = 0; k < NB; k++)
                    if (m_open[k] || !ready(rdy_rp[k])) ok = 1'b0;
            end
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    task automatic model_step(input bit g);
        int b;
        b = int'(req_bank);
        if (g) begin
            case (req_cmd)
                3'd1: begin
                    m_open[b] = 1; m_act_at[b] = cyc;
                    rdy_rcd[b] = cyc + int'(cfg_trcd); rdy_ras[b] = cyc + int'(cfg_tras);
                    rdy_rc[b] = cyc + int'(cfg_trc); rdy_rrd = cyc + int'(cfg_trrd);
                end
                3'd4: if (m_open[b]) begin m_open[b] = 0; rdy_rp[b] = cyc + int'(cfg_trp); end
                3'd5: for (int k = 0; k < NB; k++)
                    if (m_open[k]) begin m_open[k] = 0; rdy_rp[k] = cyc + int'(cfg_trp); end
                3'd6: begin rdy_quiet = cyc + int'(cfg_trc); m_pend = 0; end
                3'd7: rdy_quiet = cyc + int'(cfg_tmrd);
                default: ;
            endcase
        end
        cyc++;
        if (cyc % int'(cfg_refi) == 0) m_pend = 1;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        if (!ok) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        bit eg;
        logic [3:0] eo, ec;
        eg = model_grant();
        vectors++;
        chk(grant == eg, tag_of(req_cmd), "grant", int'(grant), int'(eg));
        // R9: echo of the granted command; R11: zero code when idle
        chk(grant_cmd == (eg ? req_cmd : 3'd0), eg ? "R9" : "R11", "grant_cmd",
            int'(grant_cmd), int'(eg ? req_cmd : 3'd0));
        if (eg) chk(grant_bank == req_bank, "R9", "grant_bank", int'(grant_bank), int'(req_bank));
        chk(refresh_req == m_pend, "R8", "refresh_req", int'(refresh_req), int'(m_pend));
        for (int k = 0; k < NB; k++) begin
            eo[k] = m_open[k][0];
            ec[k] = m_open[k][0] && ((cyc - m_act_at[k]) >= int'(cfg_tras_max));
        end
        chk(bank_open == eo, "R9", "bank_open", int'(bank_open), int'(eo));
        chk(close_req == ec, "R10", "close_req", int'(close_req), int'(ec));
        last_granted = eg;
        model_step(eg);
    endtask

    task automatic pick_request();
        int r;
        if (!last_granted && req_valid && ($urandom_range(0, 99) < 60)) return;
        req_valid = ($urandom_range(0, 99) < 85);
        req_bank  = 2'($urandom_range(0, 3));
        r = $urandom_range(0, 99);
        if (refresh_req && r < 15)  req_cmd = 3'd6;
        else if (r < 32)            req_cmd = 3'd1;
        else if (r < 45)            req_cmd = 3'd2;
        else if (r < 57)            req_cmd = 3'd3;
        else if (r < 78)            req_cmd = 3'd4;
        else if (r < 85)            req_cmd = 3'd5;
        else if (r < 91)            req_cmd = 3'd6;
        else if (r < 95)            req_cmd = 3'd7;
        else                        req_cmd = 3'd0;
    endtask

    task automatic run_phase(input int n, input logic [3:0] rcd, ras, rc, rp, rrd,
                             mrd, input logic [15:0] refi, amax);
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; req_cmd = 3'd0; req_bank = 2'd0;
        cfg_trcd = rcd; cfg_tras = ras; cfg_trc = rc; cfg_trp = rp;
        cfg_trrd = rrd; cfg_tmrd = mrd; cfg_refi = refi; cfg_tras_max = amax;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        // R1: reset state
        vectors++;
        chk(bank_open == 4'd0 && refresh_req == 1'b0 && grant == 1'b0 && close_req == 4'd0,
            "R1", "reset state", int'({refresh_req, bank_open}), 0);
        compare_all();
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            pick_request();
            #1;
            compare_all();
        end
    endtask

    initial begin
        #(MAXCYC * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_cmd = 3'd0; req_bank = 2'd0;
        void'($urandom(32'h5D1A));
        run_phase(8000, 4'd3, 4'd6, 4'd9, 4'd3, 4'd2, 4'd2, 16'd150, 16'd30);
        run_phase(8000, 4'd2, 4'd5, 4'd7, 4'd2, 4'd2, 4'd2, 16'd97, 16'd12);
        run_phase(3000, 4'd0, 4'd1, 4'd1, 4'd0, 4'd1, 4'd0, 16'd1, 16'd0);
        run_phase(5000, 4'd4, 4'd9, 4'd15, 4'd5, 4'd4, 4'd3, 16'd400, 16'd60);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule